// File: doc/BRIEF.md
# Banked Interrupt Distributor Register Bank

This block is the register store of an interrupt distributor shared by several processors. For every interrupt line it holds an enable bit, a pending bit, an active bit, an 8-bit priority and an 8-bit CPU target byte. Processors reach these through single-beat requests. Each request carries an offset, an access size and the 3-bit ID of the processor that issued it. The block answers every request one cycle later with read data and an error flag.

Interrupts 0 to 31 are private to each processor. IDs 0 to 15 are software-generated and IDs 16 to 31 are per-processor peripherals. Their enable, pending and active bits, and their priority bytes, exist once per processor, and the requester's ID picks the copy. Interrupts 32 and up have one copy that all processors share. A resolver next to this block selects a processor on `view_cpu`. It then sees that processor's complete enable, pending, active, priority and target state as flat vectors, with no added delay.

Top module: `gicd_regbank`

## Requirements
- R1: Every accepted request (`req_valid` high) gives exactly one `rsp_valid` pulse on the following cycle. No response appears without a request. A write response carries `rsp_rdata` = 0.
- R2: The enable vector has a set window at offset 0x100 and a clear window at 0x180. The word index is (offset − window base) >> 2. A set write ORs the data into the word. A clear write ANDs the word with the inverted data. A read from either window returns the same stored word.
- R3: The pending vector (set 0x200, clear 0x280) and the active vector (set 0x300, clear 0x380) follow the same set, clear and read rules as R2, each with one store behind both windows.
- R4: Word 0 (interrupts 0–31) of the enable, pending and active vectors is kept separately for each processor and is selected by `req_cpu`. Words 1 and up are one copy that every processor reads and writes.
- R5: Set-pending and clear-pending writes to word 0 never change bits 15:0, which belong to the software-generated IDs 0–15. Bits 31:16 of the same word are written normally.
- R6: Priority bytes are at 0x400 + n. `req_size` 0, 1 and 2 select 1, 2 and 4 bytes. Data byte k, counted from the least significant byte, belongs to interrupt n + k. Read lanes above the access size return zero.
- R7: Priority bytes of interrupts 0–31 are kept separately for each processor. Bytes of interrupts 32 and up are shared.
- R8: Target bytes are at 0x800 + n, with the same sizes and lane order as R6. For n ≥ 32 they are read/write storage. For n < 32 every byte read returns the requester's one-hot mask (1 << `req_cpu`), and writes to them have no effect.
- R9: A request is an error if any of these holds: it hits none of the windows above; it targets a vector word at or beyond NUM_IRQS/32; it is a byte access with `req_size` = 3 or with bytes past interrupt NUM_IRQS − 1; or it has `req_cpu` ≥ NUM_CPUS. An error returns `rsp_err` = 1 and `rsp_rdata` = 0 and changes no state.
- R10: After reset all enable, pending, active, priority and shared target state is zero. The `view_*` outputs show the stored state for the processor on `view_cpu` combinationally, and the banked target lanes show that processor's one-hot mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | 3 | ID of the requesting processor |
| req_offset | input | 12 | Byte offset within the register block |
| req_size | input | 2 | Byte-window access size: 0 = 1, 1 = 2, 2 = 4 bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Request was unmapped or malformed |
| view_cpu | input | 3 | Processor whose banked state the resolver sees |
| view_enable | output | NUM_IRQS | Enable bit per interrupt |
| view_pending | output | NUM_IRQS | Pending bit per interrupt |
| view_active | output | NUM_IRQS | Active bit per interrupt |
| view_prio | output | NUM_IRQS*8 | Priority byte per interrupt, interrupt n at bits 8n+7:8n |
| view_target | output | NUM_IRQS*8 | Target byte per interrupt, same layout |

## Verification
The bench builds the block with NUM_CPUS = 4 and NUM_IRQS = 64. This leaves a single shared vector word, so word 2 is the first out-of-range word. Interrupt 63 is the last byte a priority or target access may touch, so accesses that end exactly on it and one byte past it are both reachable. With four processors, IDs 4 to 7 fit in the 3-bit field but are rejected. This exercises the check that keeps an oversized ID from aliasing onto bank 1. The private/shared split is crossed by 2- and 4-byte accesses that start at bytes 30 and 31.

// File: rtl/gicd_pkg.sv
package gicd_pkg;

  localparam int PRIV_IRQS = 32;   // banked per processor
  localparam int SGI_IRQS  = 16;   // software-generated IDs inside the private range
  localparam int CPU_W     = 3;
  localparam int OFF_W     = 12;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_ENABLE,
    REG_PEND,
    REG_ACTIVE,
    REG_PRIO,
    REG_TARGET
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic        set_op;    // bit-vector windows: 1 = set, 0 = clear
    logic [4:0]  word;      // bit-vector word index
    logic [9:0]  byte_idx;  // first interrupt of a byte access
    logic [2:0]  nbytes;    // 1, 2 or 4; 0 for an illegal size
    logic        err;
  } dec_t;

endpackage

// File: rtl/gicd_decode.sv
module gicd_decode
  import gicd_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_IRQS = 128
) (
  input  logic [CPU_W-1:0] cpu,
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       size,
  output dec_t             dec
);

  localparam int NUM_WORDS = NUM_IRQS / 32;

  always_comb begin
    dec          = '0;
    dec.kind     = REG_NONE;
    dec.set_op   = ~offset[7];
    dec.word     = offset[6:2];
    dec.byte_idx = offset[9:0];
    case (size)
      2'd0:    dec.nbytes = 3'd1;
      2'd1:    dec.nbytes = 3'd2;
      2'd2:    dec.nbytes = 3'd4;
      default: dec.nbytes = 3'd0;
    endcase

    if (offset[11:8] == 4'h1 || offset[11:8] == 4'h2 || offset[11:8] == 4'h3) begin
      case (offset[9:8])
        2'd1:    dec.kind = REG_ENABLE;
        2'd2:    dec.kind = REG_PEND;
        default: dec.kind = REG_ACTIVE;
      endcase
      dec.err = (int'(dec.word) >= NUM_WORDS);
    end else if (offset[11:10] == 2'b01 || offset[11:10] == 2'b10) begin
      dec.kind = offset[11] ? REG_TARGET : REG_PRIO;
      dec.err  = (dec.nbytes == 3'd0) ||
                 (int'(dec.byte_idx) + int'(dec.nbytes) > NUM_IRQS);
    end else begin
      dec.err = 1'b1;
    end

    if (int'(cpu) >= NUM_CPUS) dec.err = 1'b1;
  end

endmodule

// File: rtl/gicd_bitvec.sv
module gicd_bitvec
  import gicd_pkg::*;
#(
  parameter int          NUM_CPUS  = 8,
  parameter int          NUM_WORDS = 4,
  parameter logic [31:0] LOCK_MASK = 32'h0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_set,
  input  logic [CPU_W-1:0]       acc_cpu,
  input  logic [4:0]             acc_word,
  input  logic [31:0]            wr_data,
  output logic [31:0]            rd_data,
  input  logic [CPU_W-1:0]       view_cpu,
  output logic [NUM_WORDS*32-1:0] view_vec
);

  localparam int CIDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
  localparam int WIDX_W = $clog2(NUM_WORDS);

  logic [NUM_CPUS-1:0][31:0]  bank_q, bank_d;
  logic [NUM_WORDS-1:1][31:0] shr_q, shr_d;
  logic [CIDX_W-1:0]          acc_ci, view_ci;
  logic [WIDX_W-1:0]          acc_wi;
  logic                       is_priv, view_ok;
  logic [31:0]                eff_mask;

  assign acc_ci   = acc_cpu[CIDX_W-1:0];
  assign view_ci  = view_cpu[CIDX_W-1:0];
  assign acc_wi   = acc_word[WIDX_W-1:0];
  assign is_priv  = (acc_word == 5'd0);
  assign view_ok  = (int'(view_cpu) < NUM_CPUS);
  assign eff_mask = is_priv ? (wr_data & ~LOCK_MASK) : wr_data;

  // next state
  always_comb begin
    bank_d = bank_q;
    shr_d  = shr_q;
    if (is_priv)
      bank_d[acc_ci] = wr_set ? (bank_q[acc_ci] | eff_mask) : (bank_q[acc_ci] & ~eff_mask);
    else
      shr_d[acc_wi]  = wr_set ? (shr_q[acc_wi] | eff_mask) : (shr_q[acc_wi] & ~eff_mask);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      shr_q  <= '0;
    end else if (wr_en) begin
      bank_q <= bank_d;
      shr_q  <= shr_d;
    end
  end

  assign rd_data  = is_priv ? bank_q[acc_ci] : shr_q[acc_wi];
  assign view_vec = {shr_q, (view_ok ? bank_q[view_ci] : 32'h0)};

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank_chk
    assert_bank_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(acc_cpu) != c) |=> $stable(bank_q[c]));
    assert_sgi_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((bank_q[c] & LOCK_MASK) == ($past(bank_q[c]) & LOCK_MASK)));
  end

  for (genvar w = 1; w < NUM_WORDS; w++) begin : g_shr_chk
    assert_set_only_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_set) |=> ((shr_q[w] & $past(shr_q[w])) == $past(shr_q[w])));
    assert_clr_only_shrinks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_set) |=> ((shr_q[w] | $past(shr_q[w])) == $past(shr_q[w])));
  end

endmodule

// File: rtl/gicd_bytes.sv
module gicd_bytes
  import gicd_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_IRQS = 128,
  parameter bit BANK_RO  = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CPU_W-1:0]        acc_cpu,
  input  logic [9:0]              acc_base,
  input  logic [2:0]              acc_nbytes,
  input  logic [31:0]             wr_data,
  output logic [31:0]             rd_data,
  input  logic [CPU_W-1:0]        view_cpu,
  output logic [NUM_IRQS*8-1:0]   view_bytes
);

  localparam int NSH    = NUM_IRQS - PRIV_IRQS;
  localparam int SH_W   = $clog2(NSH);
  localparam int CIDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;

  logic [3:0][10:0]      lane_idx;
  logic [3:0][SH_W-1:0]  lane_sh;
  logic [3:0]            lane_on, lane_priv;
  logic [NSH-1:0][7:0]   shr_q, shr_d;
  logic [31:0][7:0]      priv_rd, priv_view;
  logic                  view_ok;

  assign view_ok = (int'(view_cpu) < NUM_CPUS);

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_idx[k]  = {1'b0, acc_base} + 11'(k);
    assign lane_on[k]   = (3'(k) < acc_nbytes);
    assign lane_priv[k] = (lane_idx[k] < 11'(PRIV_IRQS));
    assign lane_sh[k]   = SH_W'(lane_idx[k] - 11'(PRIV_IRQS));
    assign rd_data[8*k +: 8] = !lane_on[k]  ? 8'h00 :
                               lane_priv[k] ? priv_rd[lane_idx[k][4:0]] :
                                              shr_q[lane_sh[k]];
  end

  // shared entries: next state and registers
  always_comb begin
    shr_d = shr_q;
    for (int k = 0; k < 4; k++)
      if (lane_on[k] && !lane_priv[k]) shr_d[lane_sh[k]] = wr_data[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shr_q <= '0;
    else if (wr_en) shr_q <= shr_d;
  end

  if (BANK_RO) begin : g_ro
    // private entries read back as the requester's one-hot mask
    assign priv_rd   = {32{8'(8'd1 << acc_cpu)}};
    assign priv_view = view_ok ? {32{8'(8'd1 << view_cpu)}} : '0;
  end else begin : g_rw
    logic [NUM_CPUS-1:0][31:0][7:0] bank_q, bank_d;
    logic [CIDX_W-1:0]              acc_ci, view_ci;

    assign acc_ci  = acc_cpu[CIDX_W-1:0];
    assign view_ci = view_cpu[CIDX_W-1:0];

    always_comb begin
      bank_d = bank_q;
      for (int k = 0; k < 4; k++)
        if (lane_on[k] && lane_priv[k]) bank_d[acc_ci][lane_idx[k][4:0]] = wr_data[8*k +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bank_q <= '0;
      else if (wr_en) bank_q <= bank_d;
    end

    assign priv_rd   = bank_q[acc_ci];
    assign priv_view = view_ok ? bank_q[view_ci] : '0;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_iso
      assert_prio_bank_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(acc_cpu) != c) |=> $stable(bank_q[c]));
    end
  end

  assign view_bytes = {shr_q, priv_view};

endmodule

// File: rtl/gicd_regbank.sv
module gicd_regbank
  import gicd_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_IRQS = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [2:0]            req_cpu,
  input  logic [11:0]           req_offset,
  input  logic [1:0]            req_size,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_rdata,
  output logic                  rsp_err,
  input  logic [2:0]            view_cpu,
  output logic [NUM_IRQS-1:0]   view_enable,
  output logic [NUM_IRQS-1:0]   view_pending,
  output logic [NUM_IRQS-1:0]   view_active,
  output logic [NUM_IRQS*8-1:0] view_prio,
  output logic [NUM_IRQS*8-1:0] view_target
);

  localparam int          NUM_WORDS = NUM_IRQS / 32;
  localparam logic [31:0] SGI_LOCK  = (32'h1 << SGI_IRQS) - 32'h1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  dec_t dec;
  logic acc_ok, wr_ok;

  gicd_decode #(.NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS)) u_decode (
    .cpu(req_cpu), .offset(req_offset), .size(req_size), .dec(dec)
  );

  assign acc_ok = req_valid && !dec.err;
  assign wr_ok  = acc_ok && req_write;

  // three bit-vector stores; only pending locks the software IDs
  logic [2:0][31:0]         bv_rd;
  logic [2:0][NUM_IRQS-1:0] bv_view;

  for (genvar g = 0; g < 3; g++) begin : g_vec
    localparam reg_kind_e   GK   = (g == 0) ? REG_ENABLE : (g == 1) ? REG_PEND : REG_ACTIVE;
    localparam logic [31:0] LOCK = (g == 1) ? SGI_LOCK : 32'h0;

    gicd_bitvec #(.NUM_CPUS(NUM_CPUS), .NUM_WORDS(NUM_WORDS), .LOCK_MASK(LOCK)) u_vec (
      .clk(clk), .rst_n(rst_int_n),
      .wr_en(wr_ok && dec.kind == GK), .wr_set(dec.set_op),
      .acc_cpu(req_cpu), .acc_word(dec.word), .wr_data(req_wdata),
      .rd_data(bv_rd[g]), .view_cpu(view_cpu), .view_vec(bv_view[g])
    );
  end

  assign view_enable  = bv_view[0];
  assign view_pending = bv_view[1];
  assign view_active  = bv_view[2];

  logic [31:0] prio_rd, tgt_rd;

  gicd_bytes #(.NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS), .BANK_RO(1'b0)) u_prio (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_ok && dec.kind == REG_PRIO),
    .acc_cpu(req_cpu), .acc_base(dec.byte_idx), .acc_nbytes(dec.nbytes),
    .wr_data(req_wdata), .rd_data(prio_rd), .view_cpu(view_cpu), .view_bytes(view_prio)
  );

  gicd_bytes #(.NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS), .BANK_RO(1'b1)) u_target (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_ok && dec.kind == REG_TARGET),
    .acc_cpu(req_cpu), .acc_base(dec.byte_idx), .acc_nbytes(dec.nbytes),
    .wr_data(req_wdata), .rd_data(tgt_rd), .view_cpu(view_cpu), .view_bytes(view_target)
  );

  // response: next state
  logic [31:0] sel_rd, rdata_d;
  logic        valid_d, err_d;

  always_comb begin
    case (dec.kind)
      REG_ENABLE: sel_rd = bv_rd[0];
      REG_PEND:   sel_rd = bv_rd[1];
      REG_ACTIVE: sel_rd = bv_rd[2];
      REG_PRIO:   sel_rd = prio_rd;
      REG_TARGET: sel_rd = tgt_rd;
      default:    sel_rd = 32'h0;
    endcase
    valid_d = req_valid;
    err_d   = req_valid && dec.err;
    rdata_d = (acc_ok && !req_write) ? sel_rd : 32'h0;
  end

  // response: registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= valid_d;
      rsp_err   <= err_d;
      rsp_rdata <= rdata_d;
    end
  end

  assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> !rsp_valid);
  assert_wr_rsp_zero_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_write) |=> (rsp_rdata == 32'h0));
  assert_err_no_data_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));

endmodule

// File: tb/test_gicd_regbank.sv
module test_gicd_regbank;

  localparam int CPUS = 4;
  localparam int IRQS = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [2:0]        req_cpu, view_cpu;
  logic [11:0]       req_offset;
  logic [1:0]        req_size;
  logic [31:0]       req_wdata, rsp_rdata;
  logic              rsp_valid, rsp_err;
  logic [IRQS-1:0]   view_enable, view_pending, view_active;
  logic [IRQS*8-1:0] view_prio, view_target;

  always #5 clk = ~clk;

  gicd_regbank #(.NUM_CPUS(CPUS), .NUM_IRQS(IRQS)) i_gicd_regbank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cpu(req_cpu), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .view_cpu(view_cpu), .view_enable(view_enable),
    .view_pending(view_pending), .view_active(view_active),
    .view_prio(view_prio), .view_target(view_target)
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one request, expectation queued for the monitor
  task automatic access(input bit wr, input int cpu, input int off, input int sz,
                        input logic [31:0] wd, input logic [31:0] ed, input bit ee,
                        input string tag);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_cpu    = 3'(cpu);
    req_offset = 12'(off);
    req_size   = 2'(sz);
    req_wdata  = wd;
    exp_q.push_back('{data: ed, err: ee, tag: tag});
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  task automatic wr(input int cpu, input int off, input int sz, input logic [31:0] d, input string tag);
    access(1'b1, cpu, off, sz, d, 32'h0, 1'b0, tag);
  endtask

  task automatic rd(input int cpu, input int off, input int sz, input logic [31:0] e, input string tag);
    access(1'b0, cpu, off, sz, 32'h0, e, 1'b0, tag);
  endtask

  task automatic bad(input bit w, input int cpu, input int off, input int sz, input string tag);
    access(w, cpu, off, sz, 32'hFFFF_FFFF, 32'h0, 1'b1, tag);
  endtask

  // monitor: every response is compared against the queue head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 response without request", {31'h0, rsp_err, rsp_rdata}, 64'h0);
      end else begin
        mon_e = exp_q.pop_front();
        check(rsp_rdata === mon_e.data && rsp_err === mon_e.err, mon_e.tag,
              {31'h0, rsp_err, rsp_rdata}, {31'h0, mon_e.err, mon_e.data});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_cpu = '0;
    req_offset = '0; req_size = '0; req_wdata = '0; view_cpu = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    check(view_enable == '0 && view_pending == '0 && view_active == '0, "R10 reset vectors",
          {view_pending[31:0], view_enable[31:0]}, 64'h0);
    check(view_prio == '0, "R10 reset priorities", 64'(view_prio[63:0]), 64'h0);
    check(view_target[31:0] == 32'h0101_0101 && view_target[IRQS*8-1:256] == '0,
          "R10 reset targets", 64'(view_target[31:0]), 64'h0101_0101);
    rd(0, 'h100, 2, 32'h0, "R10 enable word0 after reset");

    // R2: enable set/clear on shared word 1
    wr(0, 'h104, 2, 32'h0000_00F0, "R1 write response");
    rd(0, 'h104, 2, 32'h0000_00F0, "R2 set-enable OR");
    rd(0, 'h184, 2, 32'h0000_00F0, "R2 clear window reads same word");
    wr(0, 'h184, 2, 32'h0000_0030, "R2 clear write");
    rd(0, 'h104, 2, 32'h0000_00C0, "R2 clear-enable AND-NOT");

    // R4: banked word 0
    wr(1, 'h100, 2, 32'h1234_0001, "R4 banked write");
    rd(1, 'h180, 2, 32'h1234_0001, "R4 own bank");
    rd(2, 'h100, 2, 32'h0, "R4 other bank untouched");
    rd(2, 'h184, 2, 32'h0000_00C0, "R4 shared word seen by all");

    // R5 / R3: pending with locked software IDs
    wr(0, 'h200, 2, 32'hFFFF_FFFF, "R5 set-pending word0");
    rd(0, 'h200, 2, 32'hFFFF_0000, "R5 software IDs not set");
    wr(0, 'h280, 2, 32'hFFFF_FFFF, "R5 clear-pending word0");
    rd(0, 'h280, 2, 32'h0, "R5 upper bits cleared");
    wr(0, 'h204, 2, 32'h8000_0001, "R3 set-pending word1");
    rd(2, 'h284, 2, 32'h8000_0001, "R3 pending clear window reads same word");

    // R3: active
    wr(3, 'h300, 2, 32'h0000_00FF, "R3 set-active");
    rd(3, 'h380, 2, 32'h0000_00FF, "R3 active both windows");
    wr(3, 'h380, 2, 32'h0000_000F, "R3 clear-active");
    rd(3, 'h300, 2, 32'h0000_00F0, "R3 active after clear");
    rd(0, 'h300, 2, 32'h0, "R4 active bank of another processor");

    // R10: view follows view_cpu
    view_cpu = 3'd1;
    #1;
    check(view_enable == {32'h0000_00C0, 32'h1234_0001}, "R10 view enable cpu1",
          64'(view_enable), {32'h0000_00C0, 32'h1234_0001});
    check(view_pending == {32'h8000_0001, 32'h0}, "R10 view pending cpu1",
          64'(view_pending), {32'h8000_0001, 32'h0});
    view_cpu = 3'd3;
    #1;
    check(view_active[31:0] == 32'h0000_00F0, "R10 view active cpu3",
          64'(view_active[31:0]), 64'h0000_00F0);

    // R6 / R7: priorities across the private/shared split
    wr(0, 'h41E, 2, 32'hA1B2_C3D4, "R6 4-byte priority write");
    rd(0, 'h41E, 1, 32'h0000_C3D4, "R6 2-byte read low lanes");
    rd(1, 'h41E, 1, 32'h0, "R7 private priority banked");
    rd(1, 'h420, 1, 32'h0000_A1B2, "R7 shared priority");
    rd(0, 'h41C, 2, 32'hC3D4_0000, "R6 lane order");
    wr(2, 'h43F, 0, 32'h0000_005A, "R6 byte write last interrupt");
    rd(0, 'h43C, 2, 32'h5A00_0000, "R6 4-byte read ending at last interrupt");
    rd(1, 'h43F, 0, 32'h0000_005A, "R6 byte read");
    view_cpu = 3'd0;
    #1;
    check(view_prio[30*8 +: 8] == 8'hD4 && view_prio[33*8 +: 8] == 8'hA1,
          "R10 view priority", {48'h0, view_prio[33*8 +: 8], view_prio[30*8 +: 8]}, 64'hA1D4);

    // R8: targets
    rd(2, 'h800, 2, 32'h0404_0404, "R8 banked target one-hot");
    rd(0, 'h81C, 2, 32'h0101_0101, "R8 banked target cpu0");
    wr(1, 'h800, 2, 32'hFFFF_FFFF, "R8 banked target write");
    rd(1, 'h800, 2, 32'h0202_0202, "R8 banked target write ignored");
    wr(0, 'h820, 2, 32'h0807_0605, "R8 shared target write");
    rd(1, 'h820, 2, 32'h0807_0605, "R8 shared target read");
    rd(3, 'h821, 0, 32'h0000_0006, "R8 shared target byte");
    rd(3, 'h81F, 1, 32'h0000_0508, "R8 access crossing into shared");
    #1;
    check(view_target[33*8 +: 8] == 8'h06, "R8 view shared target",
          64'(view_target[33*8 +: 8]), 64'h06);

    // R9: errors leave state alone
    bad(0, 0, 'h108, 2, "R9 vector word out of range");
    bad(0, 0, 'h000, 2, "R9 unmapped low offset");
    bad(0, 0, 'hC00, 2, "R9 unmapped high offset");
    bad(0, 0, 'h400, 3, "R9 illegal size");
    bad(1, 0, 'h43E, 2, "R9 priority past last interrupt");
    rd(0, 'h43C, 2, 32'h5A00_0000, "R9 priorities unchanged after error");
    bad(1, 5, 'h100, 2, "R9 processor ID out of range");
    rd(1, 'h100, 2, 32'h1234_0001, "R9 no alias onto bank 1");
    bad(1, 0, 'h208, 2, "R9 pending word out of range");
    #1;
    check(view_pending == {32'h8000_0001, 32'h0}, "R9 pending unchanged",
          64'(view_pending), {32'h8000_0001, 32'h0});

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1 every request answered", 64'(exp_q.size()), 64'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule